// File: doc/BRIEF.md
# Serial NOR Page-Program Sequencer

This block turns one write request (start address, byte count and a stream of data bytes) into a series of page-program commands for a serial NOR flash. It never lets one program command run past a page boundary. The page size it uses is the smaller of two values: the device page size, given as a log2 input, and a write-size limit fixed at build time as a power of two. Each chunk runs the same sequence:

1. Poll the flash status register until the busy bit clears.
2. Send write-enable.
3. Read the status register back and confirm that the write-enable latch is set.
4. Send the program command, the address and the data.

After the last chunk, one more busy poll runs before completion is reported.

The output side is a byte-exchange interface towards an external SPI serializer. The block drives a chip-select framing signal and offers one byte at a time. The serializer accepts a byte with a ready strobe and returns, in the same cycle, the byte it shifted in. Address width is three or four bytes, chosen by a mode input.

Top module: `nor_prog_seq`

## Requirements
- R1: The effective page size is 2^min(devPageLog2, MAX_WR_LOG2) bytes.
- R2: Each program command carries min(remaining bytes, page size − (address AND (page size − 1))) data bytes, so no command crosses an effective page boundary. Chunks follow each other with addresses increasing without gaps.
- R3: Before each chunk and after the last one, the block repeats status reads (opcode 0x05 followed by one dummy byte, the status taken from the byte returned with the dummy) until status bit 0 reads 0. Between reads chip select stays low for pollGap+1 cycles.
- R4: If status bit 0 still reads 1 on a read made once timeoutLimit cycles have passed since the poll began, the request ends with doneErr = 1.
- R5: Each chunk is preceded by write-enable (opcode 0x06) as its own command, then a status read. If status bit 1 reads 0, the request ends with doneErr = 2 and no program command is sent.
- R6: A program command is opcode 0x02, then the address most significant byte first (four bytes when addr4Byte = 1, the low three bytes otherwise), then the chunk's data bytes.
- R7: Completion is a one-cycle doneValid pulse. doneErr = 0 on success, and success is reported only after the final poll reads status bit 0 as 0.
- R8: Bytes are offered only while spiCs is high, and every command sits in its own chip-select frame.
- R9: reqReady is high only while the block is idle. A request presented while a request is in progress is not taken.
- R10: Data bytes go to the flash in stream order, one per data handshake. dataReady is high only in the data phase of a program command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Block idle, request taken when both high |
| reqAddr | input | 32 | Start byte address |
| reqLen | input | LEN_W | Number of bytes to write |
| devPageLog2 | input | 5 | log2 of the device page size |
| addr4Byte | input | 1 | 1: four address bytes, 0: three |
| timeoutLimit | input | TMO_W | Busy-poll timeout in cycles |
| pollGap | input | GAP_W | Extra idle cycles between status reads |
| dataValid | input | 1 | Data byte present |
| dataReady | output | 1 | Data byte consumed when both high |
| dataByte | input | 8 | Data byte |
| spiCs | output | 1 | Chip-select frame, high during a command |
| spiTxValid | output | 1 | Byte offered to the serializer |
| spiTxReady | input | 1 | Serializer takes the byte |
| spiTxByte | output | 8 | Byte to shift out |
| spiRxByte | input | 8 | Byte shifted in, valid with the accept |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 2 | 0 ok, 1 busy timeout, 2 write-enable not latched |

## Verification
The assertions check the handshake rules on every cycle: bytes are offered only inside a chip-select frame, no command is open while the block reports itself idle, a data handshake passes the stream byte straight through to the serializer, and completion is a single-cycle pulse. Other properties depend on counting across whole commands and need the bench's flash model, which decodes each frame: chunk splitting against page size and start offset, address byte order and width, the number of status polls, and the timeout and latch-failure outcomes.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;
  localparam int ADDR_W = 32;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_PROG   = 8'h02;

  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_TMO  = 2'd1;
  localparam logic [1:0] ERR_WEL  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic ldChunk;
    logic advByte;
    logic ldAddrIdx;
    logic decAddrIdx;
    logic clrTmo;
    logic incTmo;
    logic ldGap;
    logic decGap;
  } dpCtl_t;
endpackage

// File: rtl/nor_prog_dp.sv
module nor_prog_dp
  import nor_prog_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int MAX_WR_LOG2 = 4,
  parameter int TMO_W       = 16,
  parameter int GAP_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [4:0]        devPageLog2,
  input  logic              addr4Byte,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic [GAP_W-1:0]  pollGap,
  output logic [7:0]        addrByte,
  output logic              remZero,
  output logic              chunkLast,
  output logic              addrIdxZero,
  output logic              tmoHit,
  output logic              gapZero
);
  localparam int SZ_W = MAX_WR_LOG2 + 1;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [LEN_W-1:0]  chunkLeft;
  logic [1:0]        addrIdx;
  logic [TMO_W-1:0]  tmoCnt;
  logic [GAP_W-1:0]  gapCnt;

  logic [4:0]        effLog2;
  logic [SZ_W-1:0]   pageSz;
  logic [SZ_W-1:0]   pageMask;
  logic [SZ_W-1:0]   inPageOff;
  logic [LEN_W-1:0]  room;
  logic [LEN_W-1:0]  chunkNext;

  // page size limited by the write-size cap
  always_comb begin
    effLog2   = (devPageLog2 < 5'(MAX_WR_LOG2)) ? devPageLog2 : 5'(MAX_WR_LOG2);
    pageSz    = SZ_W'(1) << effLog2;
    pageMask  = pageSz - SZ_W'(1);
    inPageOff = curAddr[SZ_W-1:0] & pageMask;
    room      = LEN_W'(pageSz - inPageOff);
    chunkNext = (remLen < room) ? remLen : room;
  end

  // address byte select, most significant first
  always_comb begin
    case (addrIdx)
      2'd3:    addrByte = curAddr[31:24];
      2'd2:    addrByte = curAddr[23:16];
      2'd1:    addrByte = curAddr[15:8];
      default: addrByte = curAddr[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remLen    <= '0;
      chunkLeft <= '0;
      addrIdx   <= '0;
      tmoCnt    <= '0;
      gapCnt    <= '0;
    end else begin
      if (ctl.loadReq) begin
        curAddr <= reqAddr;
        remLen  <= reqLen;
      end else if (ctl.advByte) begin
        curAddr <= curAddr + 1'b1;
        remLen  <= remLen - 1'b1;
      end

      if (ctl.ldChunk)      chunkLeft <= chunkNext;
      else if (ctl.advByte) chunkLeft <= chunkLeft - 1'b1;

      if (ctl.ldAddrIdx)       addrIdx <= addr4Byte ? 2'd3 : 2'd2;
      else if (ctl.decAddrIdx) addrIdx <= addrIdx - 1'b1;

      if (ctl.clrTmo)                        tmoCnt <= '0;
      else if (ctl.incTmo && !(&tmoCnt))     tmoCnt <= tmoCnt + 1'b1;

      if (ctl.ldGap)                         gapCnt <= pollGap;
      else if (ctl.decGap && gapCnt != '0)   gapCnt <= gapCnt - 1'b1;
    end
  end

  assign remZero     = (remLen == '0);
  assign chunkLast   = (chunkLeft == LEN_W'(1));
  assign addrIdxZero = (addrIdx == 2'd0);
  assign tmoHit      = (tmoCnt >= timeoutLimit);
  assign gapZero     = (gapCnt == '0);
endmodule

// File: rtl/nor_prog_ctl.sv
module nor_prog_ctl
  import nor_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       dataValid,
  output logic       dataReady,
  input  logic [7:0] dataByte,
  output logic       spiCs,
  output logic       spiTxValid,
  input  logic       spiTxReady,
  output logic [7:0] spiTxByte,
  input  logic [7:0] spiRxByte,
  output logic       doneValid,
  output logic [1:0] doneErr,
  input  logic [7:0] addrByte,
  input  logic       remZero,
  input  logic       chunkLast,
  input  logic       addrIdxZero,
  input  logic       tmoHit,
  input  logic       gapZero,
  output dpCtl_t     ctl
);
  typedef enum logic [3:0] {
    S_IDLE, S_POLL_OP, S_POLL_RD, S_POLL_WAIT,
    S_WREN_PRE, S_WREN_OP, S_CHK_PRE, S_CHK_OP, S_CHK_RD,
    S_PROG_PRE, S_PROG_OP, S_PROG_ADDR, S_PROG_DATA, S_FIN
  } state_t;

  state_t     state, stateNext;
  logic [1:0] errReg, errNext;
  logic       errLoad;
  logic       txAccept;

  assign txAccept = spiTxValid && spiTxReady;

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    errNext    = ERR_NONE;
    errLoad    = 1'b0;
    reqReady   = 1'b0;
    dataReady  = 1'b0;
    spiCs      = 1'b0;
    spiTxValid = 1'b0;
    spiTxByte  = 8'h00;
    doneValid  = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          ctl.clrTmo  = 1'b1;
          stateNext   = S_POLL_OP;
        end
      end
      S_POLL_OP: begin
        spiCs = 1'b1; spiTxValid = 1'b1; spiTxByte = OP_STATUS;
        ctl.incTmo = 1'b1;
        if (txAccept) stateNext = S_POLL_RD;
      end
      S_POLL_RD: begin
        spiCs = 1'b1; spiTxValid = 1'b1;
        ctl.incTmo = 1'b1;
        if (txAccept) begin
          if (spiRxByte[BUSY_BIT]) begin
            if (tmoHit) begin
              errNext = ERR_TMO; errLoad = 1'b1; stateNext = S_FIN;
            end else begin
              ctl.ldGap = 1'b1; stateNext = S_POLL_WAIT;
            end
          end else if (remZero) begin
            errNext = ERR_NONE; errLoad = 1'b1; stateNext = S_FIN;
          end else begin
            stateNext = S_WREN_PRE;
          end
        end
      end
      S_POLL_WAIT: begin
        ctl.incTmo = 1'b1;
        ctl.decGap = 1'b1;
        if (gapZero) stateNext = S_POLL_OP;
      end
      S_WREN_PRE: stateNext = S_WREN_OP;
      S_WREN_OP: begin
        spiCs = 1'b1; spiTxValid = 1'b1; spiTxByte = OP_WREN;
        if (txAccept) stateNext = S_CHK_PRE;
      end
      S_CHK_PRE: stateNext = S_CHK_OP;
      S_CHK_OP: begin
        spiCs = 1'b1; spiTxValid = 1'b1; spiTxByte = OP_STATUS;
        if (txAccept) stateNext = S_CHK_RD;
      end
      S_CHK_RD: begin
        spiCs = 1'b1; spiTxValid = 1'b1;
        if (txAccept) begin
          if (spiRxByte[WEL_BIT]) stateNext = S_PROG_PRE;
          else begin
            errNext = ERR_WEL; errLoad = 1'b1; stateNext = S_FIN;
          end
        end
      end
      S_PROG_PRE: begin
        ctl.ldChunk   = 1'b1;
        ctl.ldAddrIdx = 1'b1;
        stateNext     = S_PROG_OP;
      end
      S_PROG_OP: begin
        spiCs = 1'b1; spiTxValid = 1'b1; spiTxByte = OP_PROG;
        if (txAccept) stateNext = S_PROG_ADDR;
      end
      S_PROG_ADDR: begin
        spiCs = 1'b1; spiTxValid = 1'b1; spiTxByte = addrByte;
        if (txAccept) begin
          ctl.decAddrIdx = 1'b1;
          if (addrIdxZero) stateNext = S_PROG_DATA;
        end
      end
      S_PROG_DATA: begin
        spiCs      = 1'b1;
        spiTxValid = dataValid;
        spiTxByte  = dataByte;
        dataReady  = spiTxReady;
        if (dataValid && spiTxReady) begin
          ctl.advByte = 1'b1;
          if (chunkLast) begin
            ctl.clrTmo = 1'b1;
            ctl.ldGap  = 1'b1;
            stateNext  = S_POLL_WAIT;
          end
        end
      end
      S_FIN: begin
        doneValid = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      errReg <= ERR_NONE;
    end else begin
      state <= stateNext;
      if (errLoad) errReg <= errNext;
    end
  end

  assign doneErr = errReg;
endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nor_prog_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int MAX_WR_LOG2 = 4,
  parameter int TMO_W       = 16,
  parameter int GAP_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [4:0]        devPageLog2,
  input  logic              addr4Byte,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic [GAP_W-1:0]  pollGap,
  input  logic              dataValid,
  output logic              dataReady,
  input  logic [7:0]        dataByte,
  output logic              spiCs,
  output logic              spiTxValid,
  input  logic              spiTxReady,
  output logic [7:0]        spiTxByte,
  input  logic [7:0]        spiRxByte,
  output logic              doneValid,
  output logic [1:0]        doneErr
);
  dpCtl_t     ctl;
  logic [7:0] addrByte;
  logic       remZero, chunkLast, addrIdxZero, tmoHit, gapZero;

  nor_prog_dp #(
    .LEN_W(LEN_W), .MAX_WR_LOG2(MAX_WR_LOG2), .TMO_W(TMO_W), .GAP_W(GAP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqLen(reqLen), .devPageLog2(devPageLog2),
    .addr4Byte(addr4Byte), .timeoutLimit(timeoutLimit), .pollGap(pollGap),
    .addrByte(addrByte), .remZero(remZero), .chunkLast(chunkLast),
    .addrIdxZero(addrIdxZero), .tmoHit(tmoHit), .gapZero(gapZero)
  );

  nor_prog_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte),
    .spiCs(spiCs), .spiTxValid(spiTxValid), .spiTxReady(spiTxReady),
    .spiTxByte(spiTxByte), .spiRxByte(spiRxByte),
    .doneValid(doneValid), .doneErr(doneErr),
    .addrByte(addrByte), .remZero(remZero), .chunkLast(chunkLast),
    .addrIdxZero(addrIdxZero), .tmoHit(tmoHit), .gapZero(gapZero),
    .ctl(ctl)
  );
endmodule

// File: rtl/nor_prog_seq_chk.sv
module nor_prog_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       spiCs,
  input logic       spiTxValid,
  input logic       spiTxReady,
  input logic [7:0] spiTxByte,
  input logic       dataValid,
  input logic       dataReady,
  input logic [7:0] dataByte,
  input logic       doneValid
);
  // R8: bytes only inside a chip-select frame
  a_r8_tx_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    spiTxValid |-> spiCs);

  // R9: idle means no open command
  a_r9_idle_no_frame: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !spiCs);

  // R10: a data handshake is the same byte accepted by the serializer
  a_r10_data_pass: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |-> (spiTxValid && spiTxReady && spiTxByte == dataByte));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R9: no acceptance while reporting completion
  a_r9_done_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !reqReady);
endmodule

bind nor_prog_seq nor_prog_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .spiCs(spiCs),
  .spiTxValid(spiTxValid), .spiTxReady(spiTxReady), .spiTxByte(spiTxByte),
  .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte),
  .doneValid(doneValid)
);

// File: tb/nor_prog_seq_tb.sv
module nor_prog_seq_tb;
  localparam int LEN_W = 12;
  localparam int MAXL  = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [31:0]      reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [4:0]       devPageLog2 = 5'd4;
  logic             addr4Byte = 1'b1;
  logic [15:0]      timeoutLimit = 16'd2000;
  logic [7:0]       pollGap = 8'd2;
  logic             dataValid = 1'b1;
  logic             dataReady;
  logic [7:0]       dataByte;
  logic             spiCs, spiTxValid, spiTxReady;
  logic [7:0]       spiTxByte, spiRxByte;
  logic             doneValid;
  logic [1:0]       doneErr;

  nor_prog_seq #(.LEN_W(LEN_W), .MAX_WR_LOG2(MAXL), .TMO_W(16), .GAP_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .devPageLog2(devPageLog2),
    .addr4Byte(addr4Byte), .timeoutLimit(timeoutLimit), .pollGap(pollGap),
    .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte),
    .spiCs(spiCs), .spiTxValid(spiTxValid), .spiTxReady(spiTxReady),
    .spiTxByte(spiTxByte), .spiRxByte(spiRxByte),
    .doneValid(doneValid), .doneErr(doneErr)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 11);
  endfunction

  // flash and serializer model
  int          busyAfter = 1;
  logic        weWorks = 1'b1;
  int          busyCnt, bIdx, dCnt, dSeen, streamIdx, cyc;
  int          nFr, statFrames, wrenFrames, dataBad;
  logic        wel, prevCs;
  logic [7:0]  op;
  logic [31:0] accAddr;
  logic [31:0] frAddr [256];
  int          frLen  [256];
  int          frHdr  [256];

  assign spiRxByte = {6'b0, wel, busyCnt != 0};
  assign dataByte  = pat(streamIdx);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    spiTxReady <= (cyc % 3) != 0;
    if (!rstN) begin
      busyCnt <= 0; bIdx <= 0; dCnt <= 0; wel <= 1'b0; prevCs <= 1'b0;
      op <= 8'h00; accAddr <= '0;
    end else begin
      prevCs <= spiCs;
      if (dataValid && dataReady) streamIdx <= streamIdx + 1;
      if (spiCs && spiTxValid && spiTxReady) begin
        bIdx <= bIdx + 1;
        if (bIdx == 0) op <= spiTxByte;
        else if (op == 8'h02 && bIdx <= (addr4Byte ? 4 : 3))
          accAddr <= {accAddr[23:0], spiTxByte};
        else if (op == 8'h02) begin
          if (spiTxByte !== pat(dSeen)) dataBad <= dataBad + 1;
          dSeen <= dSeen + 1;
          dCnt  <= dCnt + 1;
        end else if (op == 8'h05 && busyCnt != 0) busyCnt <= busyCnt - 1;
      end
      if (prevCs && !spiCs) begin
        bIdx <= 0; dCnt <= 0; accAddr <= '0;
        if (op == 8'h06) begin wel <= weWorks; wrenFrames <= wrenFrames + 1; end
        if (op == 8'h05) statFrames <= statFrames + 1;
        if (op == 8'h02) begin
          frAddr[nFr[7:0]] <= accAddr;
          frLen[nFr[7:0]]  <= dCnt;
          frHdr[nFr[7:0]]  <= bIdx - dCnt;
          nFr <= nFr + 1;
          wel <= 1'b0;
          busyCnt <= busyAfter;
        end
      end
    end
  end

  initial begin
    cyc = 0; streamIdx = 0; dSeen = 0; nFr = 0; statFrames = 0;
    wrenFrames = 0; dataBad = 0; spiTxReady = 1'b0;
  end

  int checks = 0, errors = 0;
  logic timedOut = 1'b0;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runs one request, returns doneErr
  task automatic runReq(input logic [31:0] a, input int len, output logic [1:0] err);
    int waitCnt;
    @(negedge clk);
    reqAddr = a; reqLen = LEN_W'(len); reqValid = 1'b1;
    @(negedge clk);
    reqReady_busy: begin
      reqValid = 1'b0;
    end
    waitCnt = 0;
    while (!doneValid && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!doneValid) begin
      timedOut = 1'b1;
      check(1'b0, "watchdog", waitCnt, 0);
    end
    err = doneErr;
    @(negedge clk);
    check(!doneValid, "R7 pulse width", doneValid, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [1:0] err;
    doReset();
    // reset state
    check(reqReady == 1'b1, "R9 reset ready", reqReady, 1);
    check(spiCs == 1'b0, "R8 reset cs", spiCs, 0);
    check(doneValid == 1'b0, "R7 reset done", doneValid, 0);

    // sweep: page size, mode, start address, length
    for (int pi = 0; pi < 4; pi++) begin
      for (int m = 0; m < 2; m++) begin
        for (int ai = 0; ai < 5; ai++) begin
          for (int li = 0; li < 5; li++) begin
            int pl, len, eff, chunks, fr0, st0, d0, r;
            logic [31:0] a, start;
            pl = (pi == 0) ? 2 : (pi == 1) ? 3 : (pi == 2) ? 4 : 6;
            case (ai)
              0: start = 32'h0;
              1: start = 32'h1;
              2: start = 32'h5;
              3: start = 32'hF;
              default: start = 32'h01FF_FFFE;
            endcase
            case (li)
              0: len = 1;
              1: len = 3;
              2: len = 16;
              3: len = 17;
              default: len = 40;
            endcase
            devPageLog2 = 5'(pl);
            addr4Byte = m[0];
            fr0 = nFr; st0 = statFrames; d0 = dSeen;
            runReq(start, len, err);
            check(err == 2'd0, "R7 success code", err, 0);
            // expected chunks (R1, R2)
            eff = 1 << ((pl < MAXL) ? pl : MAXL);
            a = start; r = len; chunks = 0;
            while (r > 0) begin
              int c, idx;
              c = eff - int'(a & 32'(eff - 1));
              if (r < c) c = r;
              idx = (fr0 + chunks) % 256;
              if (chunks < nFr - fr0) begin
                check(frLen[idx] == c, "R2 chunk length", frLen[idx], c);
                check(frAddr[idx] == (m ? a : (a & 32'h00FF_FFFF)), "R6 address",
                      frAddr[idx], m ? a : (a & 32'h00FF_FFFF));
                check(frHdr[idx] == (m ? 5 : 4), "R6 header bytes", frHdr[idx], m ? 5 : 4);
              end
              a = a + 32'(c); r = r - c; chunks++;
            end
            check(nFr - fr0 == chunks, "R1 chunk count", nFr - fr0, chunks);
            check(statFrames - st0 == 1 + chunks * (busyAfter + 2), "R3 status reads",
                  statFrames - st0, 1 + chunks * (busyAfter + 2));
            check(dSeen - d0 == len, "R10 data count", dSeen - d0, len);
            check(dataBad == 0, "R10 data order", dataBad, 0);
          end
        end
      end
    end

    // requests offered while busy are not taken (R9)
    begin
      int fr0;
      devPageLog2 = 5'd4; addr4Byte = 1'b1;
      fr0 = nFr;
      @(negedge clk);
      reqAddr = 32'h40; reqLen = LEN_W'(8); reqValid = 1'b1;
      @(negedge clk);
      reqAddr = 32'h77; reqLen = LEN_W'(3);
      check(reqReady == 1'b0, "R9 busy not ready", reqReady, 0);
      while (!doneValid) @(negedge clk);
      reqValid = 1'b0;
      check(doneErr == 2'd0, "R9 first result", doneErr, 0);
      @(negedge clk);
      repeat (20) @(negedge clk);
      check(nFr - fr0 == 1, "R9 one program only", nFr - fr0, 1);
      check(frAddr[fr0 % 256] == 32'h40, "R9 first address kept", frAddr[fr0 % 256], 32'h40);
      check(spiCs == 1'b0, "R9 no further command", spiCs, 0);
    end

    // busy never clears: timeout (R4)
    begin
      int fr0;
      busyAfter = 100000; timeoutLimit = 16'd60;
      fr0 = nFr;
      runReq(32'h100, 5, err);
      check(err == 2'd1, "R4 timeout code", err, 1);
      check(nFr - fr0 == 1, "R4 stops after first chunk", nFr - fr0, 1);
      busyAfter = 1; timeoutLimit = 16'd2000;
      doReset();
    end

    // write-enable latch fails (R5)
    begin
      int fr0, w0;
      weWorks = 1'b0;
      fr0 = nFr; w0 = wrenFrames;
      runReq(32'h200, 4, err);
      check(err == 2'd2, "R5 latch error code", err, 2);
      check(nFr == fr0, "R5 no program sent", nFr - fr0, 0);
      check(wrenFrames - w0 == 1, "R5 one write enable", wrenFrames - w0, 1);
      weWorks = 1'b1;
      runReq(32'h200, 4, err);
      check(err == 2'd0, "R5 recovers", err, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", 190000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule